// File: doc/BRIEF.md
# Parallel Hash-Search Worker Array

This block is a bank of identical search workers that sit behind one simple host write/read port. Each worker holds a local character buffer (a user name followed by a candidate password), a 64-bit reference digest and a sticky match flag. On a start command a worker hashes its buffer with a fixed-latency engine, compares the digest with its reference, and raises its match flag when they are equal. The hash engine is a stand-in stub with a defined digest function and a latency of `LATENCY` cycles.

The host loads each worker's distinct suffix characters once, one worker at a time. After that, a single write with the broadcast address bit set updates the same byte position in every worker, sets every reference, or starts every worker. One read with the broadcast bit set returns all match flags as a bit vector, so a search step costs one byte write, one start, the hash latency and one read. Buffer bytes that are not rewritten keep their values from run to run.

Top module: `crack_farm`

## Requirements
- R1: After reset every worker is idle with its match flag clear, its buffer and reference all zero, and `bus_rdata` is zero.
- R2: With the default parameters the write address is split as bit 7 broadcast, bits 6:5 worker index, bits 4:0 register offset; a write with bit 7 clear reaches only the indexed worker, and offsets 0 to 15 store `bus_wdata[7:0]` into that buffer byte.
- R3: A write with address bit 7 set acts on every worker at once, for buffer bytes, reference words and control alike.
- R4: Offset 16 loads reference bits 31:0 and offset 17 loads reference bits 63:32 from `bus_wdata`.
- R5: Writing offset 18 with `bus_wdata` bit 0 set starts an idle worker; its busy bit is 1 from the write edge for exactly `LATENCY` (128) clock edges and then returns to 0.
- R6: The digest is h = 0, then for buffer byte i from 0 to 15 in order h = rotate-left(h, 5) XOR byte i; at the edge where busy drops the match flag is set if h equals the reference.
- R7: The match flag stays set through later runs that do not match, until a control write with bit 1 set clears it; a clear landing on the same edge as a matching completion leaves the flag set.
- R8: While a worker is busy, writes to its buffer, its reference and its start bit have no effect.
- R9: A read (`bus_rd` high) updates `bus_rdata` on the next edge: with address bit 7 set, bit i is worker i's match flag and other bits are 0; otherwise bit 0 is the indexed worker's busy bit, bit 1 its match flag, other bits 0; without a read `bus_rdata` holds.
- R10: Buffer bytes not written keep their value across runs, so each worker keeps its own suffix while broadcast writes change a shared position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W (8) | Broadcast bit, worker index, register offset |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |

## Verification
A buffer byte stored in the wrong worker, or a broadcast that misses one worker, changes that worker's digest, so the match vector read after the next run differs from the expected one about `LATENCY` plus two cycles later. A busy counter off by one shows in a status read taken at the exact release edge, and a write that slips through while busy shows as a missing or extra match bit after that run. A match flag that clears on its own appears on the very next vector read.

// File: rtl/farm_pkg.sv
// Shared types for the hash-search worker array.
// Assumes: every worker decodes the same register offsets.
package farm_pkg;

    // Which register a write targets inside a worker window.
    typedef enum logic [2:0] {
        ACC_NONE   = 3'd0,
        ACC_BUF    = 3'd1,
        ACC_REF_LO = 3'd2,
        ACC_REF_HI = 3'd3,
        ACC_CTRL   = 3'd4
    } acc_kind_e;

    // Control word bit positions.
    localparam int CTRL_START_BIT = 0;
    localparam int CTRL_CLEAR_BIT = 1;

    // Width of a digest.
    localparam int DIGEST_W = 64;

endpackage

// File: rtl/farm_decode.sv
// Address decoder: splits the host address into broadcast bit, worker
// index and register offset, and produces one select per worker.
// Assumes: address layout {bcast, index, offset}; index values at or
// above NUM_WORKERS select nothing.
module farm_decode
    import farm_pkg::*;
#(
    parameter int NUM_WORKERS = 4,
    parameter int BUF_BYTES   = 16,
    parameter int IDX_W       = 2,
    parameter int OFS_W       = 5,
    localparam int ADDR_W     = 1 + IDX_W + OFS_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_addr,
    output logic [NUM_WORKERS-1:0] sel,
    output acc_kind_e              kind,
    output logic [OFS_W-1:0]       ofs,
    output logic                   bcast,
    output logic [IDX_W-1:0]       idx
);

    // Field extraction.
    always_comb begin
        bcast = bus_addr[ADDR_W-1];
        idx   = bus_addr[OFS_W +: IDX_W];
        ofs   = bus_addr[OFS_W-1:0];
    end

    // Classify the offset into a register kind.
    always_comb begin
        if (ofs < OFS_W'(BUF_BYTES))
            kind = ACC_BUF;
        else if (ofs == OFS_W'(BUF_BYTES))
            kind = ACC_REF_LO;
        else if (ofs == OFS_W'(BUF_BYTES + 1))
            kind = ACC_REF_HI;
        else if (ofs == OFS_W'(BUF_BYTES + 2))
            kind = ACC_CTRL;
        else
            kind = ACC_NONE;
    end

    // One select per worker: broadcast hits all, else only the indexed one.
    for (genvar w = 0; w < NUM_WORKERS; w++) begin : g_sel
        assign sel[w] = bus_wr && (kind != ACC_NONE) &&
                        (bcast || (idx == IDX_W'(w)));
    end

    // R2: a write without the broadcast bit reaches at most one worker.
    a_r2_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr[ADDR_W-1]) |-> $onehot0(sel));

    // R3: a valid broadcast write selects every worker.
    a_r3_bcast_all: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[ADDR_W-1] && kind != ACC_NONE) |-> (&sel));

endmodule

// File: rtl/farm_hash_stub.sv
// Fixed-latency stand-in for the hash engine. Busy for LATENCY edges
// after start; the digest is a rotate-and-xor fold of the input bytes
// and is valid while done is high.
// Assumes: the input bytes are held stable while busy; LATENCY >= 2.
module farm_hash_stub
    import farm_pkg::*;
#(
    parameter int BUF_BYTES = 16,
    parameter int LATENCY   = 128,
    localparam int CNT_W    = $clog2(LATENCY),
    localparam int DATA_W   = BUF_BYTES * 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [DATA_W-1:0]   data_in,
    output logic                busy,
    output logic                done,
    output logic [DIGEST_W-1:0] digest
);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;

    // Latency counter: load on start, count down, release at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                cnt_q  <= CNT_W'(LATENCY - 1);
            end
        end else if (cnt_q == '0) begin
            busy_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Digest fold over the bytes, byte 0 first.
    always_comb begin
        digest = '0;
        for (int i = 0; i < BUF_BYTES; i++) begin
            digest = {digest[DIGEST_W-6:0], digest[DIGEST_W-1:DIGEST_W-5]} ^
                     {{(DIGEST_W-8){1'b0}}, data_in[i*8 +: 8]};
        end
    end

    assign busy = busy_q;
    assign done = busy_q && (cnt_q == '0);

    // R5: an accepted start makes the engine busy on the next edge.
    a_r5_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy_q) |=> busy_q);

    // R5: busy only drops after the count has run out.
    a_r5_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> ($past(cnt_q) == '0));

endmodule

// File: rtl/farm_worker.sv
// One search worker: character buffer, reference digest, sticky match
// flag, and a hash engine instance. Buffer, reference and start are
// locked while busy; clear is always accepted, and a match wins over a
// clear on the same edge.
// Assumes: sel is a one-cycle write strobe already decoded for this worker.
module farm_worker
    import farm_pkg::*;
#(
    parameter int BUF_BYTES = 16,
    parameter int LATENCY   = 128,
    parameter int OFS_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  acc_kind_e        kind,
    input  logic [OFS_W-1:0] ofs,
    input  logic [31:0]      wdata,
    output logic             busy,
    output logic             found
);

    logic [BUF_BYTES-1:0][7:0] buf_q;
    logic [DIGEST_W-1:0]       ref_q;
    logic                      found_q;
    logic                      idle_wr;
    logic                      start_req;
    logic                      clear_req;
    logic                      hash_done;
    logic [DIGEST_W-1:0]       hash_val;

    assign idle_wr   = sel && !busy;
    assign start_req = idle_wr && (kind == ACC_CTRL) && wdata[CTRL_START_BIT];
    assign clear_req = sel && (kind == ACC_CTRL) && wdata[CTRL_CLEAR_BIT];

    // Buffer bytes: one register per byte, written only while idle.
    for (genvar b = 0; b < BUF_BYTES; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n)
                buf_q[b] <= '0;
            else if (idle_wr && kind == ACC_BUF && ofs == OFS_W'(b))
                buf_q[b] <= wdata[7:0];
        end
    end

    // Reference digest halves, written only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ref_q <= '0;
        else if (idle_wr && kind == ACC_REF_LO)
            ref_q[31:0] <= wdata;
        else if (idle_wr && kind == ACC_REF_HI)
            ref_q[63:32] <= wdata;
    end

    // Sticky match flag: set on matching completion, cleared by control.
    always_ff @(posedge clk) begin
        if (!rst_n)
            found_q <= 1'b0;
        else if (hash_done && (hash_val == ref_q))
            found_q <= 1'b1;
        else if (clear_req)
            found_q <= 1'b0;
    end

    farm_hash_stub #(
        .BUF_BYTES(BUF_BYTES),
        .LATENCY  (LATENCY)
    ) i_hash (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start_req),
        .data_in(buf_q),
        .busy   (busy),
        .done   (hash_done),
        .digest (hash_val)
    );

    assign found = found_q;

    // R8: a buffer write while busy leaves the buffer untouched.
    a_r8_buf_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sel && kind == ACC_BUF) |=> $stable(buf_q));

    // R8: a reference write while busy leaves the reference untouched.
    a_r8_ref_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sel) |=> $stable(ref_q));

    // R7: the flag stays set unless a clear arrives.
    a_r7_found_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (found_q && !clear_req) |=> found_q);

    // R6: the flag can only rise at a completion edge.
    a_r6_found_origin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(found_q) |-> $past(hash_done));

endmodule

// File: rtl/crack_farm.sv
// Top of the worker array: decoder, NUM_WORKERS workers, and the
// registered read path returning either the match vector (broadcast
// read) or one worker's {match, busy} status.
// Assumes: NUM_WORKERS <= 32 so the match vector fits the read word.
module crack_farm
    import farm_pkg::*;
#(
    parameter int NUM_WORKERS = 4,
    parameter int BUF_BYTES   = 16,
    parameter int LATENCY     = 128,
    localparam int IDX_W      = (NUM_WORKERS > 1) ? $clog2(NUM_WORKERS) : 1,
    localparam int OFS_W      = $clog2(BUF_BYTES + 3),
    localparam int ADDR_W     = 1 + IDX_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata
);

    logic [NUM_WORKERS-1:0] sel;
    logic [NUM_WORKERS-1:0] busy_vec;
    logic [NUM_WORKERS-1:0] found_vec;
    acc_kind_e              kind;
    logic [OFS_W-1:0]       ofs;
    logic                   bcast;
    logic [IDX_W-1:0]       idx;
    logic [31:0]            rd_word;
    logic [31:0]            rdata_q;

    farm_decode #(
        .NUM_WORKERS(NUM_WORKERS),
        .BUF_BYTES  (BUF_BYTES),
        .IDX_W      (IDX_W),
        .OFS_W      (OFS_W)
    ) i_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .sel     (sel),
        .kind    (kind),
        .ofs     (ofs),
        .bcast   (bcast),
        .idx     (idx)
    );

    for (genvar w = 0; w < NUM_WORKERS; w++) begin : g_worker
        farm_worker #(
            .BUF_BYTES(BUF_BYTES),
            .LATENCY  (LATENCY),
            .OFS_W    (OFS_W)
        ) i_worker (
            .clk  (clk),
            .rst_n(rst_n),
            .sel  (sel[w]),
            .kind (kind),
            .ofs  (ofs),
            .wdata(bus_wdata),
            .busy (busy_vec[w]),
            .found(found_vec[w])
        );
    end

    // Read word: match vector on broadcast, else one worker's status.
    always_comb begin
        rd_word = '0;
        if (bcast) begin
            rd_word[NUM_WORKERS-1:0] = found_vec;
        end else begin
            for (int w = 0; w < NUM_WORKERS; w++) begin
                if (idx == IDX_W'(w)) begin
                    rd_word[0] = busy_vec[w];
                    rd_word[1] = found_vec[w];
                end
            end
        end
    end

    // Read data register, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (bus_rd)
            rdata_q <= rd_word;
    end

    assign bus_rdata = rdata_q;

    // R9: without a read strobe the read data holds.
    a_r9_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R9: a status read never sets bits above the two status bits.
    a_r9_status_width: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_addr[ADDR_W-1]) |=> (bus_rdata[31:2] == '0));

endmodule

// File: tb/test_crack_farm.sv
// Self-checking bench for crack_farm: directed corner cases plus seeded
// random broadcast search rounds against a bench-side model.
module test_crack_farm;

    localparam int NW  = 4;
    localparam int NB  = 16;
    localparam int LAT = 128;
    localparam int AW  = 8;
    localparam int OFS_REF_LO = 16;
    localparam int OFS_REF_HI = 17;
    localparam int OFS_CTRL   = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [7:0]  mbuf [NW][NB];
    logic [63:0] mref [NW];
    bit          mfound [NW];

    crack_farm i_crack_farm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rd   (bus_rd),
        .bus_rdata(bus_rdata)
    );

    always #10 clk = ~clk;

    // Digest as an xor of each byte rotated by 5 per later byte (R6).
    function automatic logic [63:0] ref_hash(int w);
        logic [63:0] acc = '0;
        for (int i = 0; i < NB; i++) begin
            int r = (5 * (NB - 1 - i)) % 64;
            logic [63:0] v = {56'b0, mbuf[w][i]};
            acc ^= (r == 0) ? v : ((v << r) | (v >> (64 - r)));
        end
        return acc;
    endfunction

    function automatic logic [AW-1:0] mk_addr(bit bc, int w, int ofs);
        return {bc, 2'(w), 5'(ofs)};
    endfunction

    function automatic logic [31:0] exp_vec();
        logic [31:0] v = '0;
        for (int w = 0; w < NW; w++) v[w] = mfound[w];
        return v;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [31:0] v);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic put_byte(bit bc, int w, int p, logic [7:0] b);
        wr(mk_addr(bc, w, p), {24'h0, b});
        for (int k = 0; k < NW; k++) if (bc || k == w) mbuf[k][p] = b;
    endtask

    task automatic put_ref(bit bc, int w, logic [63:0] r);
        wr(mk_addr(bc, w, OFS_REF_LO), r[31:0]);
        wr(mk_addr(bc, w, OFS_REF_HI), r[63:32]);
        for (int k = 0; k < NW; k++) if (bc || k == w) mref[k] = r;
    endtask

    task automatic do_clear(bit bc, int w);
        wr(mk_addr(bc, w, OFS_CTRL), 32'h2);
        for (int k = 0; k < NW; k++) if (bc || k == w) mfound[k] = 1'b0;
    endtask

    task automatic run_wait(bit bc, int w);
        wr(mk_addr(bc, w, OFS_CTRL), 32'h1);
        repeat (LAT + 2) @(negedge clk);
        for (int k = 0; k < NW; k++)
            if ((bc || k == w) && ref_hash(k) == mref[k]) mfound[k] = 1'b1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] v;
        logic [7:0]  old;
        void'($urandom(32'd4242));
        for (int w = 0; w < NW; w++) begin
            mref[w] = '0; mfound[w] = 1'b0;
            for (int i = 0; i < NB; i++) mbuf[w][i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        rd(mk_addr(1, 0, 0), v); chk("R1 match vector after reset", v, 32'h0);
        rd(mk_addr(0, 2, 0), v); chk("R1 status after reset", v, 32'h0);
        // R1/R6: zero buffer hashes to zero, equal to zero reference.
        run_wait(0, 2);
        rd(mk_addr(1, 0, 0), v); chk("R1 zero buffer matches zero ref", v, exp_vec());
        do_clear(1, 0);

        // R2/R4/R6: unicast load of worker 1, matching reference.
        for (int i = 0; i < NB; i++) put_byte(0, 1, i, 8'(i * 7 + 3));
        put_ref(0, 1, ref_hash(1));
        put_ref(0, 0, 64'h1234_5678_9abc_def0);
        wr(mk_addr(0, 1, OFS_CTRL), 32'h1);
        rd(mk_addr(0, 1, 0), v); chk("R5 busy right after start", v, 32'h1);
        rd(mk_addr(0, 0, 0), v); chk("R2 unaddressed worker stays idle", v, 32'h0);
        repeat (LAT) @(negedge clk);
        mfound[1] = 1'b1;
        rd(mk_addr(1, 0, 0), v); chk("R2 R6 only worker 1 matches", v, exp_vec());
        rd(mk_addr(0, 1, 0), v); chk("R9 status of worker 1", v, 32'h2);

        // R5: exact busy length on worker 3, and set wins over clear (R7).
        for (int i = 0; i < NB; i++) put_byte(0, 3, i, 8'($urandom));
        put_ref(0, 3, ref_hash(3));
        wr(mk_addr(0, 3, OFS_CTRL), 32'h1);
        repeat (LAT - 1) @(negedge clk);
        wr(mk_addr(0, 3, OFS_CTRL), 32'h2);
        mfound[3] = 1'b1;
        rd(mk_addr(0, 3, 0), v); chk("R5 R7 released, set beats clear", v, 32'h2);
        wr(mk_addr(0, 3, OFS_CTRL), 32'h1);
        repeat (LAT - 1) @(negedge clk);
        rd(mk_addr(0, 3, 0), v); chk("R5 still busy at last busy edge", v, 32'h3);
        rd(mk_addr(0, 3, 0), v); chk("R5 idle one edge later", v, 32'h2);

        // R7: non-matching run keeps the flag; clear removes it.
        put_ref(0, 1, ~ref_hash(1));
        run_wait(0, 1);
        rd(mk_addr(1, 0, 0), v); chk("R7 flag sticky over miss", v, exp_vec());
        do_clear(0, 1);
        rd(mk_addr(1, 0, 0), v); chk("R7 flag cleared", v, exp_vec());

        // R8: writes during busy ignored.
        do_clear(1, 0);
        for (int i = 0; i < NB; i++) put_byte(0, 0, i, 8'($urandom));
        put_ref(0, 0, ref_hash(0));
        wr(mk_addr(0, 0, OFS_CTRL), 32'h1);
        old = mbuf[0][5];
        wr(mk_addr(0, 0, 5), {24'h0, ~old});
        wr(mk_addr(0, 0, OFS_REF_LO), 32'h0);
        wr(mk_addr(0, 0, OFS_CTRL), 32'h1);
        repeat (LAT - 2) @(negedge clk);
        mfound[0] = 1'b1;
        rd(mk_addr(0, 0, 0), v); chk("R8 busy writes and restart ignored", v, 32'h2);

        // R3/R9/R10: random broadcast search rounds.
        do_clear(1, 0);
        for (int w = 0; w < NW; w++)
            for (int i = 0; i < NB; i++) put_byte(0, w, i, 8'($urandom));
        for (int rnd = 0; rnd < 24; rnd++) begin
            int p = $urandom_range(NB - 1, 0);
            int t = $urandom_range(NW - 1, 0);
            int s = $urandom_range(NW - 1, 0);
            put_byte(1, 0, p, 8'($urandom));
            if ($urandom_range(3, 0) != 0) put_ref(1, 0, ref_hash(t));
            else put_ref(1, 0, {$urandom, $urandom});
            run_wait(1, 0);
            rd(mk_addr(1, 0, 0), v);
            chk("R3 R10 broadcast round match vector", v, exp_vec());
            rd(mk_addr(0, s, 0), v);
            chk("R9 per-worker status", v, {30'h0, mfound[s], 1'b0});
            do_clear(1, 0);
            rd(mk_addr(1, 0, 0), v); chk("R3 broadcast clear", v, 32'h0);
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule